// File: doc/BRIEF.md
# Concurrent Plane Access Arbiter

This block sits beside a four-plane non-volatile memory array and decides, for every host read, whether the read is answered from the array or with a busy-status word. It tracks one embedded program or erase operation and, while an erase is on hold, one nested program. A read that lands in a plane with a running operation gets status. A read to any idle plane goes straight to the array. Once an operation is suspended, the busy region shrinks. For a sector erase it becomes the erased sector, for a plane erase the plane, and for a chip erase the whole array. For a program it becomes the single word being written.

The address is a word address. Its two top bits select the plane. Plane 0 starts with eight small boot sectors of 4K words each, which together fill the lowest 32K words. Every other sector is a 32K-word main sector. Commands arrive as single-cycle pulses. Control of the array timing lies outside this block.

Top module: `plane_access_arbiter`

## Requirements
- R1: After reset no operation is held, `rd_sel_status` is 0 for every address, `status_word` is zero and `nest_prog_ok` is 0.
- R2: While a program (op_kind 0), sector erase (1) or plane erase (2) runs unsuspended, a read whose address bits [21:20] match the target's gets status and any other plane gets array data.
- R3: While a chip erase (op_kind 3) runs, every read gets status. Start and resume pulses are ignored; only suspend and done act.
- R4: With an erase suspended, status is returned only inside the erase region: the same 4K boot sector (addresses below 0x8000), the same 32K main sector, the same plane, or the whole array for a chip erase.
- R5: With a program suspended, status is returned only for the exact target word.
- R6: The status word has bit 7 equal to the complement of the programmed data bit 7 (0 for an erase) and bit 6 the toggle bit, with all other bits 0. It is all zero whenever `rd_sel_status` is 0.
- R7: Bit 6 flips after every cycle in which `rd_valid` is high and status is selected, and holds otherwise. It starts at 0.
- R8: `nest_prog_ok` is 1 exactly when an erase is suspended and no nested program runs. A program start is then accepted only outside the erase region. While that nested program runs, reads to its plane get status, and its own data bit selects bit 7.
- R9: While a nested program runs, suspend and resume pulses are ignored, and `op_done` ends the nested program rather than the erase.
- R10: `op_done` ends an unsuspended primary operation and returns all reads to the array. While the primary is suspended with no nested program, `op_done` is ignored.
- R11: A suspend pulse with no operation held is ignored. A start pulse while an operation is held and no nesting is allowed is ignored.
- R12: When several pulses coincide, only the highest acts, in the order done, suspend, resume, start. The others are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_valid | input | 1 | Host read strobe for this cycle |
| rd_addr | input | 22 | Host read word address |
| op_start | input | 1 | Start pulse for an embedded operation |
| op_kind | input | 2 | 0 program, 1 sector erase, 2 plane erase, 3 chip erase |
| op_addr | input | 22 | Target word address of the started operation |
| op_dbit7 | input | 1 | Bit 7 of the data being programmed |
| op_done | input | 1 | Running operation finished |
| susp_req | input | 1 | Suspend pulse |
| resume_req | input | 1 | Resume pulse |
| rd_sel_status | output | 1 | 1 selects the status word, 0 selects array data |
| status_word | output | 16 | Status word for the current read |
| nest_prog_ok | output | 1 | A nested program may be started now |

## Verification
The hardest state to reach from the ports is a nested program running under a suspended erase. It needs an erase start, a suspend, and then a program start whose address falls outside the erased sector, all with no done pulse in between. A done pulse there would end the nested program or be dropped. Directed sequences build this state on boot and main sectors, then try suspend, resume and a blocked same-sector start inside it. Seeded random traffic then biases read and start addresses toward the current targets, their neighbouring bits and the boot region, so that the sector, word and plane boundaries are hit often.

// File: rtl/paa_pkg.sv
`timescale 1ns/1ps
package paa_pkg;
  typedef enum logic [1:0] {
    K_PROG  = 2'd0,
    K_SECT  = 2'd1,
    K_PLANE = 2'd2,
    K_CHIP  = 2'd3
  } paa_kind_e;

  localparam int POLL_BIT = 7;
  localparam int TOG_BIT  = 6;

  function automatic logic kind_is_erase(paa_kind_e k);
    return k != K_PROG;
  endfunction
endpackage

// File: rtl/paa_region.sv
`timescale 1ns/1ps
module paa_region
  import paa_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int PLANE_W = 2,
  parameter int BOOT_W  = 12,
  parameter int MAIN_W  = 15,
  parameter int BOOT_N  = 8
) (
  input  logic              active,
  input  logic              susp,
  input  paa_kind_e         kind,
  input  logic [ADDR_W-1:0] tgt,
  input  logic [ADDR_W-1:0] probe,
  output logic              hit
);
  localparam int NPLANES = 1 << PLANE_W;
  localparam logic [ADDR_W-1:0] BOOT_SPAN = ADDR_W'(BOOT_N) << BOOT_W;

  function automatic logic [PLANE_W-1:0] plane_of(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: PLANE_W];
  endfunction

  function automatic logic in_boot(logic [ADDR_W-1:0] a);
    return a < BOOT_SPAN;
  endfunction

  function automatic logic same_sector(logic [ADDR_W-1:0] a, logic [ADDR_W-1:0] b);
    if (in_boot(a) != in_boot(b)) return 1'b0;
    if (in_boot(a)) return (a >> BOOT_W) == (b >> BOOT_W);
    return (a >> MAIN_W) == (b >> MAIN_W);
  endfunction

  logic [NPLANES-1:0] plane_busy;
  logic               run_hit;
  logic               held_hit;

  for (genvar p = 0; p < NPLANES; p++) begin : g_plane
    assign plane_busy[p] = active &&
                           (kind == K_CHIP || plane_of(tgt) == PLANE_W'(p));
  end

  assign run_hit = !susp && plane_busy[plane_of(probe)];

  always_comb begin
    held_hit = 1'b0;
    if (active && susp) begin
      unique case (kind)
        K_PROG:  held_hit = (probe == tgt);
        K_SECT:  held_hit = same_sector(probe, tgt);
        K_PLANE: held_hit = (plane_of(probe) == plane_of(tgt));
        K_CHIP:  held_hit = 1'b1;
      endcase
    end
  end

  assign hit = run_hit || held_hit;

  always_comb begin
    if (active && !susp && kind == K_CHIP)
      p_chip_all_r3: assert (hit);
    if (active && susp && kind == K_PROG && probe != tgt)
      p_word_only_r5: assert (!hit);
  end
endmodule

// File: rtl/paa_opctl.sv
`timescale 1ns/1ps
module paa_opctl
  import paa_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start,
  input  paa_kind_e         op_kind,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              op_dbit7,
  input  logic              op_done,
  input  logic              susp_req,
  input  logic              resume_req,
  input  logic              nest_block,
  output logic              p_act,
  output logic              p_susp,
  output paa_kind_e         p_kind,
  output logic [ADDR_W-1:0] p_addr,
  output logic              p_d7,
  output logic              n_act,
  output logic [ADDR_W-1:0] n_addr,
  output logic              n_d7,
  output logic              nest_ok
);
  logic ev_done_n, ev_done_p, ev_susp, ev_res, ev_start_p, ev_start_n, quiet;

  assign nest_ok = p_act && p_susp && kind_is_erase(p_kind) && !n_act;

  always_comb begin
    ev_done_n  = op_done && n_act;
    ev_done_p  = op_done && p_act && !p_susp && !n_act;
    ev_susp    = !op_done && susp_req && p_act && !p_susp && !n_act;
    ev_res     = !op_done && !susp_req && resume_req && p_act && p_susp && !n_act;
    quiet      = !op_done && !susp_req && !resume_req;
    ev_start_p = quiet && op_start && !p_act;
    ev_start_n = quiet && op_start && nest_ok && op_kind == K_PROG && !nest_block;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_act  <= 1'b0;
      p_susp <= 1'b0;
      p_kind <= K_PROG;
      p_addr <= '0;
      p_d7   <= 1'b0;
      n_act  <= 1'b0;
      n_addr <= '0;
      n_d7   <= 1'b0;
    end else begin
      if (ev_start_p) begin
        p_act  <= 1'b1;
        p_susp <= 1'b0;
        p_kind <= op_kind;
        p_addr <= op_addr;
        p_d7   <= op_dbit7;
      end
      if (ev_done_p) p_act  <= 1'b0;
      if (ev_susp)   p_susp <= 1'b1;
      if (ev_res)    p_susp <= 1'b0;
      if (ev_start_n) begin
        n_act  <= 1'b1;
        n_addr <= op_addr;
        n_d7   <= op_dbit7;
      end
      if (ev_done_n) n_act <= 1'b0;
    end
  end

  p_single_event_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_done_n, ev_done_p, ev_susp, ev_res, ev_start_p, ev_start_n}));
  p_nest_under_susp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    n_act |-> (p_act && p_susp && p_kind != K_PROG));
  p_susp_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    n_act |=> p_susp);
  p_done_to_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done_p |=> (!p_act && !n_act));
  p_idle_no_susp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_req && !p_act) |=> !p_susp);
  p_busy_keeps_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (p_act && op_start) |=> $stable(p_addr));
endmodule

// File: rtl/paa_status.sv
`timescale 1ns/1ps
module paa_status
  import paa_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic              hit,
  input  logic              poll,
  output logic [DATA_W-1:0] status_word
);
  logic tog;
  logic status_read;

  assign status_read = rd_valid && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog <= 1'b0;
    else if (status_read) tog <= !tog;
  end

  always_comb begin
    status_word = '0;
    if (hit) begin
      status_word[POLL_BIT] = poll;
      status_word[TOG_BIT]  = tog;
    end
  end

  p_tog_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    status_read |=> (tog != $past(tog)));
  p_tog_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !status_read |=> $stable(tog));
  always_comb if (!hit) p_zero_word_r6: assert (status_word == '0);
endmodule

// File: rtl/plane_access_arbiter.sv
`timescale 1ns/1ps
module plane_access_arbiter
  import paa_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int DATA_W  = 16,
  parameter int PLANE_W = 2,
  parameter int BOOT_W  = 12,
  parameter int MAIN_W  = 15,
  parameter int BOOT_N  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              op_start,
  input  logic [1:0]        op_kind,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              op_dbit7,
  input  logic              op_done,
  input  logic              susp_req,
  input  logic              resume_req,
  output logic              rd_sel_status,
  output logic [DATA_W-1:0] status_word,
  output logic              nest_prog_ok
);
  logic              p_act, p_susp, p_d7, n_act, n_d7;
  paa_kind_e         p_kind;
  logic [ADDR_W-1:0] p_addr, n_addr;
  logic              pri_hit, nst_hit, nest_block, poll;

  paa_opctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .op_start(op_start), .op_kind(paa_kind_e'(op_kind)), .op_addr(op_addr),
    .op_dbit7(op_dbit7), .op_done(op_done), .susp_req(susp_req),
    .resume_req(resume_req), .nest_block(nest_block),
    .p_act(p_act), .p_susp(p_susp), .p_kind(p_kind), .p_addr(p_addr), .p_d7(p_d7),
    .n_act(n_act), .n_addr(n_addr), .n_d7(n_d7), .nest_ok(nest_prog_ok)
  );

  paa_region #(.ADDR_W(ADDR_W), .PLANE_W(PLANE_W), .BOOT_W(BOOT_W),
               .MAIN_W(MAIN_W), .BOOT_N(BOOT_N)) u_pri (
    .active(p_act), .susp(p_susp), .kind(p_kind), .tgt(p_addr),
    .probe(rd_addr), .hit(pri_hit)
  );

  paa_region #(.ADDR_W(ADDR_W), .PLANE_W(PLANE_W), .BOOT_W(BOOT_W),
               .MAIN_W(MAIN_W), .BOOT_N(BOOT_N)) u_nst (
    .active(n_act), .susp(1'b0), .kind(K_PROG), .tgt(n_addr),
    .probe(rd_addr), .hit(nst_hit)
  );

  paa_region #(.ADDR_W(ADDR_W), .PLANE_W(PLANE_W), .BOOT_W(BOOT_W),
               .MAIN_W(MAIN_W), .BOOT_N(BOOT_N)) u_blk (
    .active(p_act), .susp(1'b1), .kind(p_kind), .tgt(p_addr),
    .probe(op_addr), .hit(nest_block)
  );

  assign rd_sel_status = pri_hit || nst_hit;
  assign poll = nst_hit ? !n_d7 : (p_kind == K_PROG ? !p_d7 : 1'b0);

  paa_status #(.DATA_W(DATA_W)) u_sts (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .hit(rd_sel_status),
    .poll(poll), .status_word(status_word)
  );

  p_idle_array_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!p_act && !n_act) |-> !rd_sel_status);
  p_nest_plane_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (n_act && rd_addr[ADDR_W-1 -: PLANE_W] == n_addr[ADDR_W-1 -: PLANE_W]) |-> rd_sel_status);
endmodule

// File: tb/plane_access_arbiter_tb.sv
`timescale 1ns/1ps
module plane_access_arbiter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_valid = 1'b0;
  logic [21:0] rd_addr = '0;
  logic        op_start = 1'b0;
  logic [1:0]  op_kind = '0;
  logic [21:0] op_addr = '0;
  logic        op_dbit7 = 1'b0;
  logic        op_done = 1'b0;
  logic        susp_req = 1'b0;
  logic        resume_req = 1'b0;
  logic        rd_sel_status;
  logic [15:0] status_word;
  logic        nest_prog_ok;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // bench model of the requirements
  logic        m_pa = 0, m_ps = 0, m_pd7 = 0, m_na = 0, m_nd7 = 0, m_tog = 0;
  logic [1:0]  m_pk = 0;
  logic [21:0] m_paddr = 0, m_naddr = 0;

  plane_access_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .op_start(op_start), .op_kind(op_kind), .op_addr(op_addr), .op_dbit7(op_dbit7),
    .op_done(op_done), .susp_req(susp_req), .resume_req(resume_req),
    .rd_sel_status(rd_sel_status), .status_word(status_word), .nest_prog_ok(nest_prog_ok)
  );

  always #2.5 clk = ~clk;

  function automatic int b_sector(logic [21:0] a);
    if (a < 22'd32768) return int'(a) / 4096;
    return 7 + int'(a) / 32768;
  endfunction

  function automatic logic b_hit(logic act, logic susp, logic [1:0] k,
                                 logic [21:0] t, logic [21:0] p);
    if (!act) return 1'b0;
    if (!susp) return (k == 2'd3) || (t[21:20] == p[21:20]);
    case (k)
      2'd0: return t == p;
      2'd1: return b_sector(t) == b_sector(p);
      2'd2: return t[21:20] == p[21:20];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic b_nest_ok();
    return m_pa && m_ps && m_pk != 2'd0 && !m_na;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input string tag);
    logic n_hit, p_hit, e_sel, poll;
    logic [15:0] e_word;
    string t;
    #1;
    p_hit = b_hit(m_pa, m_ps, m_pk, m_paddr, rd_addr);
    n_hit = b_hit(m_na, 1'b0, 2'd0, m_naddr, rd_addr);
    e_sel = p_hit || n_hit;
    poll = n_hit ? ~m_nd7 : (m_pk == 2'd0 ? ~m_pd7 : 1'b0);
    e_word = e_sel ? {8'h00, poll, m_tog, 6'h00} : 16'h0;
    if (tag != "") t = tag;
    else if (n_hit) t = "R8";
    else if (m_pa && m_ps) t = (m_pk == 2'd0) ? "R5" : "R4";
    else if (m_pa && m_pk == 2'd3) t = "R3";
    else if (m_pa) t = "R2";
    else t = "R10";
    if (rd_valid) begin
      check(t, rd_sel_status, e_sel);
      check("R6", status_word, e_word);
    end
    check("R8", nest_prog_ok, b_nest_ok());
    @(posedge clk);
    if (rd_valid && e_sel) m_tog = ~m_tog;
    if (op_done) begin
      if (m_na) m_na = 0;
      else if (m_pa && !m_ps) m_pa = 0;
    end else if (susp_req) begin
      if (m_pa && !m_ps && !m_na) m_ps = 1;
    end else if (resume_req) begin
      if (m_pa && m_ps && !m_na) m_ps = 0;
    end else if (op_start) begin
      if (!m_pa) begin
        m_pa = 1; m_ps = 0; m_pk = op_kind; m_paddr = op_addr; m_pd7 = op_dbit7;
      end else if (b_nest_ok() && op_kind == 2'd0 &&
                   !b_hit(1'b1, 1'b1, m_pk, m_paddr, op_addr)) begin
        m_na = 1; m_naddr = op_addr; m_nd7 = op_dbit7;
      end
    end
    @(negedge clk);
    rd_valid = 0; op_start = 0; op_done = 0; susp_req = 0; resume_req = 0;
  endtask

  task automatic t_read(input logic [21:0] a, input string tag);
    rd_valid = 1; rd_addr = a; step(tag);
  endtask
  task automatic t_start(input logic [1:0] k, input logic [21:0] a, input logic d7);
    op_start = 1; op_kind = k; op_addr = a; op_dbit7 = d7; step("");
  endtask
  task automatic t_done();   op_done = 1;    step(""); endtask
  task automatic t_susp();   susp_req = 1;   step(""); endtask
  task automatic t_res();    resume_req = 1; step(""); endtask

  task automatic pick_addr(output logic [21:0] a);
    case ($urandom % 6)
      0: a = 22'($urandom);
      1: a = m_paddr;
      2: a = m_paddr ^ (22'd1 << ($urandom % 22));
      3: a = 22'($urandom % 32768);
      4: a = m_naddr;
      default: a = {m_paddr[21:20], 20'($urandom)};
    endcase
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    #1;
    check("R1", nest_prog_ok, 0);
    @(negedge clk);
    t_read(22'h000000, "R1");
    t_read(22'h3fffff, "R1");
    check("R1", status_word, 16'h0);

    // R2 program on plane 1, data bit7 = 1
    t_start(2'd0, 22'h100005, 1'b1);
    t_read(22'h100200, "R2");
    t_read(22'h100200, "R7");       // toggle flipped
    t_read(22'h000010, "R2");       // array read leaves toggle
    t_read(22'h100005, "R7");
    // R11 start while busy is ignored
    t_start(2'd0, 22'h000040, 1'b0);
    t_read(22'h000040, "R11");
    // R5 program suspend
    t_susp();
    t_read(22'h100005, "R5");
    t_read(22'h100006, "R5");
    t_res();
    t_read(22'h100006, "R2");
    t_done();
    t_read(22'h100005, "R10");

    // R4/R8 boot sector erase, suspend, nested program
    t_start(2'd1, 22'h003005, 1'b0);
    t_susp();
    t_read(22'h003fff, "R4");
    t_read(22'h004000, "R4");
    t_read(22'h002fff, "R4");
    t_start(2'd0, 22'h003010, 1'b1); // same sector: blocked
    t_read(22'h003010, "R8");
    t_start(2'd0, 22'h200010, 1'b0); // nested accepted
    t_read(22'h2abcde, "R8");
    t_susp();                         // R9 ignored
    t_res();                          // R9 ignored
    t_read(22'h003001, "R9");
    t_read(22'h100000, "R9");
    t_done();                         // R9 ends nested only
    t_read(22'h003001, "R9");
    t_read(22'h200010, "R9");
    t_done();                         // R10 ignored while suspended
    t_read(22'h003001, "R10");
    t_res();
    t_done();
    t_read(22'h003001, "R10");

    // R4 main sector erase
    t_start(2'd1, 22'h150123, 1'b0);
    t_susp();
    t_read(22'h157fff, "R4");
    t_read(22'h158000, "R4");
    t_read(22'h148000, "R4");
    t_res(); t_done();

    // R4 plane erase suspended
    t_start(2'd2, 22'h0a0000, 1'b0);
    t_susp();
    t_read(22'h0fffff, "R4");
    t_read(22'h100000, "R4");
    t_res(); t_done();

    // R3 chip erase
    t_start(2'd3, 22'h000000, 1'b0);
    t_read(22'h3ffff0, "R3");
    t_read(22'h123456, "R3");
    t_start(2'd0, 22'h300000, 1'b1);
    t_res();
    t_read(22'h000001, "R3");
    t_done();
    t_read(22'h300000, "R3");

    // R11 suspend while idle
    t_susp();
    t_start(2'd0, 22'h000100, 1'b0);
    t_read(22'h000101, "R11");
    // R12 done and suspend together: done wins
    op_done = 1; susp_req = 1; step("");
    t_read(22'h000100, "R12");
    // R12 suspend and resume together: suspend wins
    t_start(2'd1, 22'h250000, 1'b0);
    susp_req = 1; resume_req = 1; step("");
    t_read(22'h240000, "R12");
    t_read(22'h250001, "R12");
    check("R12", nest_prog_ok, 1);
    t_res(); t_done();

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [21:0] a;
      r = $urandom % 100;
      if (r < 5) begin
        pick_addr(a);
        op_start = 1; op_kind = 2'($urandom % 4); op_addr = a; op_dbit7 = 1'($urandom);
        if ($urandom % 4 == 0) op_kind = 2'd0;
      end else if (r < 11) op_done = 1;
      else if (r < 15) susp_req = 1;
      else if (r < 19) resume_req = 1;
      if ($urandom % 10 == 0) susp_req = 1'($urandom);
      if ($urandom % 4 != 0) begin
        pick_addr(a);
        rd_valid = 1; rd_addr = a;
      end
      step("");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule